// File: doc/BRIEF.md
# Decrement Unit with Status Flags

This block subtracts one from a 64-bit operand at one of four operand widths and produces both the new register value and an updated status-flag word. The arithmetic flags that describe the result are recomputed at the selected width, while the carry flag and every non-arithmetic bit of the incoming flag word pass through untouched. This lets a loop counter step down without disturbing a pending carry.

The unit is a single registered stage. The caller presents the full 64-bit destination register, a width code, the current flag word and a valid strobe. One clock later the unit presents the destination value after write-back merging, the new flag word and an output valid strobe. For narrow widths the merge keeps the register's upper bits. A 32-bit result clears the upper half.

Top module: `dec_flag_unit`

## Requirements
- R1: The low bits of `res_o` at the selected width equal the operand minus one, wrapping modulo 2^width (zero becomes all ones). Width codes on `size_i`: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits.
- R2: Write-back merge works as follows. For width codes 0 and 1, bits above the width keep the operand's bits. For code 2, bits 63..32 are zero. For code 3, all 64 bits are the difference.
- R3: Flag bit 0 (carry) and flag bits 1, 3, 5, 8, 9, 10 and 12..15 of `flags_o` equal the same bits of `flags_i`.
- R4: Flag bit 11 (overflow) is set exactly when the operand, at the selected width, has only its sign bit set.
- R5: Flag bit 7 (sign) equals the most significant result bit at the selected width.
- R6: Flag bit 6 (zero) is set exactly when all result bits at the selected width are zero.
- R7: Flag bit 4 (nibble borrow) is set exactly when operand bits 3..0 are all zero.
- R8: Flag bit 2 (parity) is set exactly when result bits 7..0 hold an even number of ones.
- R9: `vld_o` is high in the cycle after each cycle where `vld_i` is high, and low otherwise. `res_o` and `flags_o` hold their values while no input is valid. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Operation request strobe |
| size_i | input | 2 | Operand width code |
| opnd_i | input | 64 | Destination register value |
| flags_i | input | 16 | Incoming status-flag word |
| vld_o | output | 1 | Result strobe, one cycle after `vld_i` |
| res_o | output | 64 | Merged destination value |
| flags_o | output | 16 | Updated status-flag word |

## Verification
The only state in the unit is the output register. A wrong width selection or a wrong merge shows up on `res_o` or `flags_o` in the very next cycle after the request. A corrupted hold path shows up in the first idle cycle, because the outputs drift while `vld_o` is low. Corner operands at each width are the ones that expose a mistaken width: zero, one, only the sign bit, all ones, and a zero low nibble. Each of these sets a different flag.

// File: rtl/dec_flag_unit.sv
module dec_flag_unit #(
  parameter int FLAG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [1:0]        size_i,
  input  logic [63:0]       opnd_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              vld_o,
  output logic [63:0]       res_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int B_PAR = 2;
  localparam int B_NIB = 4;
  localparam int B_ZRO = 6;
  localparam int B_SGN = 7;
  localparam int B_OVF = 11;

  logic [63:0] diff;
  logic [63:0] merged;
  logic        f_sgn, f_zro, f_ovf, f_nib, f_par;
  logic [FLAG_W-1:0] nflags;

  assign diff = opnd_i - 64'd1;

  always_comb begin
    case (size_i)
      2'd0: begin
        merged = {opnd_i[63:8], diff[7:0]};
        f_sgn  = diff[7];
        f_zro  = diff[7:0] == '0;
        f_ovf  = opnd_i[7:0] == 8'h80;
      end
      2'd1: begin
        merged = {opnd_i[63:16], diff[15:0]};
        f_sgn  = diff[15];
        f_zro  = diff[15:0] == '0;
        f_ovf  = opnd_i[15:0] == 16'h8000;
      end
      2'd2: begin
        merged = {32'd0, diff[31:0]};
        f_sgn  = diff[31];
        f_zro  = diff[31:0] == '0;
        f_ovf  = opnd_i[31:0] == 32'h8000_0000;
      end
      default: begin
        merged = diff;
        f_sgn  = diff[63];
        f_zro  = diff == '0;
        f_ovf  = opnd_i == 64'h8000_0000_0000_0000;
      end
    endcase
  end

  assign f_nib = opnd_i[3:0] == 4'd0;
  assign f_par = ~^diff[7:0];

  always_comb begin
    nflags        = flags_i;
    nflags[B_PAR] = f_par;
    nflags[B_NIB] = f_nib;
    nflags[B_ZRO] = f_zro;
    nflags[B_SGN] = f_sgn;
    nflags[B_OVF] = f_ovf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o   <= 1'b0;
      res_o   <= '0;
      flags_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        res_o   <= merged;
        flags_o <= nflags;
      end
    end
  end
endmodule

// File: rtl/dec_flag_unit_chk.sv
module dec_flag_unit_chk #(
  parameter int FLAG_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vld_i,
  input logic [1:0]        size_i,
  input logic [63:0]       opnd_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic              vld_o,
  input logic [63:0]       res_o,
  input logic [FLAG_W-1:0] flags_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) vld_i |=> vld_o); // R9
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !vld_i |=> !vld_o); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !vld_i |=> ($stable(res_o) && $stable(flags_o))); // R9
  AST_CARRY_KEEP: assert property (@(posedge clk) disable iff (!rst_n) vld_i |=> flags_o[0] == $past(flags_i[0])); // R3
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (vld_i && size_i == 2'd0) |=> res_o[63:8] == $past(opnd_i[63:8])); // R2
  AST_ZERO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n) (vld_i && size_i == 2'd2) |=> res_o[63:32] == 32'd0); // R2
  AST_NIBBLE_BORROW: assert property (@(posedge clk) disable iff (!rst_n) vld_i |=> flags_o[4] == ($past(opnd_i[3:0]) == 4'd0)); // R7
  AST_PARITY_OUT: assert property (@(posedge clk) disable iff (!rst_n) vld_o |-> flags_o[2] == ~^res_o[7:0]); // R8
  AST_ZERO_WIDE: assert property (@(posedge clk) disable iff (!rst_n) (vld_i && size_i == 2'd3) |=> flags_o[6] == (res_o == 64'd0)); // R6
endmodule

bind dec_flag_unit dec_flag_unit_chk #(.FLAG_W(FLAG_W)) u_chk (.*);

// File: tb/dec_flag_unit_tb.sv
module dec_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [63:0] opnd_i = '0;
  logic [15:0] flags_i = '0;
  logic        vld_o;
  logic [63:0] res_o;
  logic [15:0] flags_o;
  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dec_flag_unit u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wbits(input logic [1:0] s);
    return 8 << s;
  endfunction

  task automatic run_op(input logic [1:0] s, input logic [63:0] op, input logic [15:0] fi);
    int w;
    logic [63:0] mask, low, exp_r;
    logic [15:0] exp_f;
    w = wbits(s);
    mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
    low = (op - 1) & mask;
    if (s == 2'd2) exp_r = low;
    else exp_r = (op & ~mask) | low;
    exp_f = fi;
    exp_f[11] = (op & mask) == (64'd1 << (w - 1));
    exp_f[7]  = low[w-1];
    exp_f[6]  = low == 0;
    exp_f[4]  = op[3:0] == 0;
    exp_f[2]  = ($countones(low[7:0]) % 2) == 0;
    @(negedge clk);
    vld_i = 1'b1; size_i = s; opnd_i = op; flags_i = fi;
    @(negedge clk);
    vld_i = 1'b0;
    chk("R9 valid", {63'd0, vld_o}, 64'd1);
    chk("R1 R2 result", res_o, exp_r);
    chk("R3 passthru", {48'd0, flags_o & 16'hF72B}, {48'd0, fi & 16'hF72B});
    chk("R4 ovf", {63'd0, flags_o[11]}, {63'd0, exp_f[11]});
    chk("R5 sign", {63'd0, flags_o[7]}, {63'd0, exp_f[7]});
    chk("R6 zero", {63'd0, flags_o[6]}, {63'd0, exp_f[6]});
    chk("R7 nibble", {63'd0, flags_o[4]}, {63'd0, exp_f[4]});
    chk("R8 parity", {63'd0, flags_o[2]}, {63'd0, exp_f[2]});
  endtask

  task automatic t_reset;
    chk("R9 reset vld", {63'd0, vld_o}, 64'd0);
    chk("R9 reset res", res_o, 64'd0);
    chk("R9 reset flags", {48'd0, flags_o}, 64'd0);
  endtask

  task automatic t_corners;
    for (int s = 0; s < 4; s++) begin
      int w = wbits(2'(s));
      run_op(2'(s), 64'hA5A5_5A5A_C3C3_0000, 16'h0000);
      run_op(2'(s), 64'hFFFF_FFFF_FFFF_FF01, 16'hFFFF);
      run_op(2'(s), 64'h1234_5678_9ABC_DEF0 & ~((w == 64) ? 64'h0 : ((64'd1 << w) - 1)) | (64'd1 << (w - 1)), 16'h0001);
      run_op(2'(s), 64'hFFFF_FFFF_FFFF_FFFF, 16'h0800);
      run_op(2'(s), 64'h0000_0000_0000_0010, 16'h0000);
    end
  endtask

  task automatic t_carry;
    run_op(2'd0, 64'h10, 16'h0001);
    run_op(2'd3, 64'h0, 16'hF72B);
    run_op(2'd1, 64'h1, 16'h0000);
  endtask

  task automatic t_random;
    for (int i = 0; i < 200; i++)
      run_op(2'($urandom_range(0, 3)), {$urandom, $urandom}, 16'($urandom));
  endtask

  task automatic t_idle;
    logic [63:0] r;
    logic [15:0] f;
    run_op(2'd2, 64'hFFFF_0000_0000_0001, 16'h0001);
    r = res_o; f = flags_o;
    @(negedge clk);
    size_i = 2'd3; opnd_i = 64'h55; flags_i = 16'hAAAA;
    @(negedge clk);
    @(negedge clk);
    chk("R9 idle vld", {63'd0, vld_o}, 64'd0);
    chk("R9 idle res", res_o, r);
    chk("R9 idle flags", {48'd0, f}, {48'd0, flags_o});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_corners();
    t_carry();
    t_random();
    t_idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL R9 watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule